// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block works out how many master-clock cycles fit into one period of the sample-rate clock (the left/right frame clock). It then reports which of six ratios the link runs at: 128, 192, 256, 384, 512 or 768 master clocks per sample. The filter and modulator clock dividers downstream take their setting from the reported code. No configuration input exists. Any period count that fits no ratio is reported as 768 per sample.

The frame clock is synchronised into the master-clock domain, and its rising edges bound each measurement. A reported code changes only after two back-to-back periods classify to the same ratio, and a lock flag shows that this agreement is in force. A timeout counter runs on a separate free-running oscillator clock and watches the master clock for activity. When the master clock stops for about 1.5 µs (the timeout length is a parameter), the counter raises a digital reset request. That request also returns the detector to its reset state until the master clock runs again.

Top module: `mclk_ratio_det`

## Requirements
- R1: The period is counted in master-clock cycles between two successive frame-clock rising edges. The code is 0 for 128, 1 for 192, 2 for 256, 3 for 384, 4 for 512 and 5 for 768 clocks per sample.
- R2: A period matches a ratio when it lies within MATCH_TOL (32) clocks of that ratio's nominal count, with both limits inclusive (96 gives code 0, 352 gives code 3, 288 gives code 2).
- R3: When a period matches two ratios, the smaller ratio wins: 160 gives code 0 and 224 gives code 1.
- R4: A period that matches no ratio is classified as code 5 (for example 95, 289, 700 or 801 clocks).
- R5: The reported code changes only when a measured period classifies to the same code as the period just before it. At that point ratio_locked goes to 1.
- R6: A period whose class differs from the previous one drops ratio_locked to 0. The reported code keeps its old value.
- R7: After any reset, the first frame-clock rising edge only starts a measurement. It produces no classification.
- R8: While rst_n is low, ratio_code is 5, ratio_locked is 0 and stop_rst is 0.
- R9: stop_rst stays 0 while the master clock runs. It rises about STOP_TICKS oscillator cycles after the last master-clock edge: not before STOP_TICKS-3 cycles and no later than STOP_TICKS+7 cycles.
- R10: While stop_rst is high, ratio_code is 5 and ratio_locked is 0. stop_rst falls once master-clock activity is seen again, and the detector then restarts from its reset state.
- R11: ratio_code and ratio_locked update at the second master-clock rising edge after the edge that first samples the frame clock high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock for the stop timeout |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Master clock being measured |
| lrclk | input | 1 | Frame (sample-rate) clock, asynchronous to mclk |
| ratio_code | output | 3 | Detected ratio code (0..5) |
| ratio_locked | output | 1 | Two consecutive periods agreed on ratio_code |
| stop_rst | output | 1 | Digital reset request after the master clock stops |

## Verification
Two events can fall on the same master-clock edge: the lock decision of one period and the start of the next measurement. A single frame-clock rise ends period N, compares its class with period N-1 and restarts the counter. The bench moves between patterns whose classes agree, disagree and overlap at the tolerance boundaries. A behavioural model, which counts edges and keeps the last classification, predicts the code and lock flag on every master-clock cycle. The second interplay is between the stop timeout and the detector state. The bench halts the master clock in the middle of a locked stream and checks that the reset request clears the lock. It then resumes the clock and checks that the next lock takes two fresh periods.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

   localparam int NUM_RT = 6;

   typedef enum logic [2:0] {
      RT_128 = 3'd0,
      RT_192 = 3'd1,
      RT_256 = 3'd2,
      RT_384 = 3'd3,
      RT_512 = 3'd4,
      RT_768 = 3'd5
   } rt_code_t;

   localparam rt_code_t RT_DEFAULT = RT_768;

   // nominal master clocks per sample for each code, ascending
   function automatic int rt_nominal(input int idx);
      case (idx)
         0:       return 128;
         1:       return 192;
         2:       return 256;
         3:       return 384;
         4:       return 512;
         default: return 768;
      endcase
   endfunction

endpackage

// File: rtl/mcr_lr_sync.sv
module mcr_lr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mcr_lr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], din};
         prev <= sh[STAGES-1];
      end
   end

   assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/mcr_period_cls.sv
module mcr_period_cls
   import mcr_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int TOL   = 32
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     rise,
   output logic     meas_vld,
   output rt_code_t meas_code
);
   localparam int SPAN_MAX = (1 << CNT_W);

   if (SPAN_MAX <= 768 + TOL) begin : g_bad_width
      $error("mcr_period_cls: CNT_W too narrow for the largest ratio");
   end
   if (TOL < 0 || TOL > 63) begin : g_bad_tol
      $error("mcr_period_cls: TOL out of range");
   end

   logic [CNT_W-1:0] cnt;
   logic             have_edge;
   logic [CNT_W:0]   span;
   logic [NUM_RT-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         have_edge <= 1'b0;
      end else if (rise) begin
         cnt       <= '0;
         have_edge <= 1'b1;
      end else if (cnt != {CNT_W{1'b1}}) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign span = {1'b0, cnt} + 1'b1;

   for (genvar i = 0; i < NUM_RT; i++) begin : g_win
      localparam int LO = rt_nominal(i) - TOL;
      localparam int HI = rt_nominal(i) + TOL;
      assign hit[i] = (int'(span) >= LO) && (int'(span) <= HI);
   end

   // lowest ratio wins where windows touch
   always_comb begin
      meas_code = RT_DEFAULT;
      for (int i = NUM_RT - 1; i >= 0; i--) begin
         if (hit[i]) meas_code = rt_code_t'(3'(i));
      end
   end

   assign meas_vld = rise & have_edge;
endmodule

// File: rtl/mcr_lock.sv
module mcr_lock
   import mcr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     meas_vld,
   input  rt_code_t meas_code,
   output rt_code_t cur_code,
   output logic     locked
);
   rt_code_t cand;
   logic     cand_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand     <= RT_DEFAULT;
         cand_vld <= 1'b0;
         cur_code <= RT_DEFAULT;
         locked   <= 1'b0;
      end else if (meas_vld) begin
         if (cand_vld && (meas_code == cand)) begin
            cur_code <= meas_code;
            locked   <= 1'b1;
         end else begin
            locked <= 1'b0;
         end
         cand     <= meas_code;
         cand_vld <= 1'b1;
      end
   end
endmodule

// File: rtl/mcr_stop_watch.sv
module mcr_stop_watch #(
   parameter int STOP_TICKS  = 375,
   parameter int SYNC_STAGES = 2
) (
   input  logic osc_clk,
   input  logic mclk,
   input  logic rst_n,
   output logic mclk_seen,
   output logic stop_rst
);
   localparam int TW = $clog2(STOP_TICKS + 1);

   if (STOP_TICKS < 8) begin : g_bad_ticks
      $error("mcr_stop_watch: STOP_TICKS must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mcr_stop_watch: SYNC_STAGES must be at least 2");
   end

   logic                 tgl;
   logic [SYNC_STAGES:0] tsh;
   logic [TW-1:0]        idle;

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) tgl <= 1'b0;
      else        tgl <= ~tgl;
   end

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) tsh <= '0;
      else        tsh <= {tsh[SYNC_STAGES-1:0], tgl};
   end

   assign mclk_seen = tsh[SYNC_STAGES] ^ tsh[SYNC_STAGES-1];

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         idle     <= '0;
         stop_rst <= 1'b0;
      end else if (mclk_seen) begin
         idle     <= '0;
         stop_rst <= 1'b0;
      end else if (idle == TW'(STOP_TICKS)) begin
         stop_rst <= 1'b1;
      end else begin
         idle <= idle + 1'b1;
      end
   end
endmodule

// File: rtl/mclk_ratio_det.sv
module mclk_ratio_det
   import mcr_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int MATCH_TOL  = 32,
   parameter int LR_SYNC    = 2,
   parameter int STOP_TICKS = 375,
   parameter int ACT_SYNC   = 2
) (
   input  logic       osc_clk,
   input  logic       rst_n,
   input  logic       mclk,
   input  logic       lrclk,
   output logic [2:0] ratio_code,
   output logic       ratio_locked,
   output logic       stop_rst
);
   logic     mclk_seen;
   logic     clr_n;
   logic [1:0] rs;
   logic     det_rst_n;
   logic     lr_rise;
   logic     meas_vld;
   rt_code_t meas_code;
   rt_code_t cur_code;

   mcr_stop_watch #(
      .STOP_TICKS (STOP_TICKS),
      .SYNC_STAGES(ACT_SYNC)
   ) u_stop (
      .osc_clk  (osc_clk),
      .mclk     (mclk),
      .rst_n    (rst_n),
      .mclk_seen(mclk_seen),
      .stop_rst (stop_rst)
   );

   // detector reset: asserted at once, released on mclk
   assign clr_n = rst_n & ~stop_rst;

   always_ff @(posedge mclk or negedge clr_n) begin
      if (!clr_n) rs <= 2'b00;
      else        rs <= {rs[0], 1'b1};
   end

   assign det_rst_n = rs[1];

   mcr_lr_sync #(.STAGES(LR_SYNC)) u_lr (
      .clk  (mclk),
      .rst_n(det_rst_n),
      .din  (lrclk),
      .rise (lr_rise)
   );

   mcr_period_cls #(.CNT_W(CNT_W), .TOL(MATCH_TOL)) u_cls (
      .clk      (mclk),
      .rst_n    (det_rst_n),
      .rise     (lr_rise),
      .meas_vld (meas_vld),
      .meas_code(meas_code)
   );

   mcr_lock u_lock (
      .clk      (mclk),
      .rst_n    (det_rst_n),
      .meas_vld (meas_vld),
      .meas_code(meas_code),
      .cur_code (cur_code),
      .locked   (ratio_locked)
   );

   assign ratio_code = cur_code;
endmodule

// File: rtl/mcr_chk.sv
module mcr_chk (
   input logic       mclk,
   input logic       osc_clk,
   input logic       rst_n,
   input logic       det_rst_n,
   input logic       lr_rise,
   input logic       mclk_seen,
   input logic [2:0] ratio_code,
   input logic       ratio_locked,
   input logic       stop_rst
);
   // R1
   code_range_chk: assert property (@(posedge mclk) disable iff (!det_rst_n)
      ratio_code <= 3'd5);

   // R5
   code_change_chk: assert property (@(posedge mclk) disable iff (!det_rst_n)
      !$stable(ratio_code) |-> (ratio_locked && $past(lr_rise)));

   // R6
   lock_drop_chk: assert property (@(posedge mclk) disable iff (!det_rst_n)
      $fell(ratio_locked) |-> ($past(lr_rise) && $stable(ratio_code)));

   // R11
   lock_hold_chk: assert property (@(posedge mclk) disable iff (!det_rst_n)
      (ratio_locked && !lr_rise) |=> ($stable(ratio_code) && ratio_locked));

   // R9
   stop_rise_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $rose(stop_rst) |-> !$past(mclk_seen));

   // R10
   stop_fall_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $fell(stop_rst) |-> $past(mclk_seen));
endmodule

bind mclk_ratio_det mcr_chk u_chk (
   .mclk        (mclk),
   .osc_clk     (osc_clk),
   .rst_n       (rst_n),
   .det_rst_n   (det_rst_n),
   .lr_rise     (lr_rise),
   .mclk_seen   (mclk_seen),
   .ratio_code  (ratio_code),
   .ratio_locked(ratio_locked),
   .stop_rst    (stop_rst)
);

// File: tb/test_mclk_ratio_det.sv
`timescale 1ns/1ps
module test_mclk_ratio_det;
   localparam int STOP_TICKS = 375;

   logic       osc_clk = 1'b0;
   logic       mclk = 1'b0;
   logic       mclk_run = 1'b1;
   logic       rst_n = 1'b0;
   logic       lrclk = 1'b0;
   logic [2:0] ratio_code;
   logic       ratio_locked;
   logic       stop_rst;

   int n_chk = 0;
   int n_bad = 0;

   mclk_ratio_det #(.STOP_TICKS(STOP_TICKS)) i_mclk_ratio_det (
      .osc_clk     (osc_clk),
      .rst_n       (rst_n),
      .mclk        (mclk),
      .lrclk       (lrclk),
      .ratio_code  (ratio_code),
      .ratio_locked(ratio_locked),
      .stop_rst    (stop_rst)
   );

   always #2 osc_clk = ~osc_clk;               // 250 MHz
   always #5 if (mclk_run || mclk) mclk = ~mclk; // 100 MHz, halts low

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model
   function automatic int classify(input int n);
      int noms[6] = '{128, 192, 256, 384, 512, 768};
      for (int i = 0; i < 6; i++) begin
         if (n >= noms[i] - 32 && n <= noms[i] + 32) return i;
      end
      return 5;
   endfunction

   bit m_act = 1'b0;
   bit stop_chk = 1'b0;
   bit hq[$];
   int cyc, last_rise, m_code, m_cand;
   bit m_have, m_cvld, m_lock;

   task automatic model_reset();
      hq.delete();
      cyc = 0; last_rise = 0; m_code = 5; m_cand = 5;
      m_have = 0; m_cvld = 0; m_lock = 0;
   endtask

   always @(posedge mclk) begin
      if (m_act) begin
         hq.push_front(lrclk);
         if (hq.size() > 4) void'(hq.pop_back());
         cyc++;
         if (hq.size() == 4 && hq[2] && !hq[3]) begin
            if (m_have) begin
               int c;
               c = classify(cyc - last_rise);
               if (m_cvld && c == m_cand) begin
                  m_code = c;
                  m_lock = 1;
               end else begin
                  m_lock = 0;
               end
               m_cand = c;
               m_cvld = 1;
            end
            m_have = 1;
            last_rise = cyc;
         end
      end
   end

   // R11: per-cycle comparison against the model
   always @(negedge mclk) begin
      if (m_act) begin
         chk("R11 code", int'(ratio_code), m_code);
         chk("R11 lock", int'(ratio_locked), int'(m_lock));
      end
   end

   // R9: no stop request while mclk runs
   always @(negedge osc_clk) begin
      if (stop_chk) chk("R9 running", int'(stop_rst), 0);
   end

   task automatic lr_periods(input int n, input int reps);
      for (int r = 0; r < reps; r++) begin
         for (int c = 0; c < n; c++) begin
            @(negedge mclk);
            lrclk = (c < n / 2);
         end
      end
   endtask

   task automatic pattern(input string req, input int n, input int exp_code);
      lr_periods(n, 3);
      chk(req, int'(ratio_code), exp_code);
      chk(req, int'(ratio_locked), 1);
   endtask

   initial begin
      model_reset();
      repeat (10) @(negedge osc_clk);
      // R8
      chk("R8 code", int'(ratio_code), 5);
      chk("R8 lock", int'(ratio_locked), 0);
      chk("R8 stop", int'(stop_rst), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge mclk);
      m_act = 1'b1;
      stop_chk = 1'b1;

      // R7: first rise only starts measuring
      lr_periods(256, 2);
      chk("R7 code", int'(ratio_code), 5);
      chk("R7 lock", int'(ratio_locked), 0);
      lr_periods(256, 1);
      chk("R5 code", int'(ratio_code), 2);
      chk("R5 lock", int'(ratio_locked), 1);

      // R6: a disagreeing period
      lr_periods(384, 2);
      chk("R6 held code", int'(ratio_code), 2);
      chk("R6 lock drop", int'(ratio_locked), 0);
      lr_periods(384, 1);
      chk("R5 relock code", int'(ratio_code), 3);
      chk("R5 relock", int'(ratio_locked), 1);

      pattern("R4 95", 95, 5);
      pattern("R2 96", 96, 0);
      pattern("R3 160", 160, 0);
      pattern("R3 224", 224, 1);
      pattern("R2 288", 288, 2);
      pattern("R4 289", 289, 5);
      pattern("R2 352", 352, 3);
      pattern("R1 512", 512, 4);
      pattern("R4 700", 700, 5);
      pattern("R1 192", 192, 1);
      pattern("R4 801", 801, 5);
      pattern("R1 128", 128, 0);
      pattern("R1 768", 768, 5);
      pattern("R1 256", 256, 2);

      // R9 / R10: stop the master clock while locked
      stop_chk = 1'b0;
      @(negedge mclk);
      m_act = 1'b0;
      mclk_run = 1'b0;
      repeat (STOP_TICKS - 3) @(negedge osc_clk);
      chk("R9 early", int'(stop_rst), 0);
      repeat (10) @(negedge osc_clk);
      chk("R9 fired", int'(stop_rst), 1);
      chk("R10 code cleared", int'(ratio_code), 5);
      chk("R10 lock cleared", int'(ratio_locked), 0);

      mclk_run = 1'b1;
      repeat (30) @(negedge mclk);
      chk("R10 released", int'(stop_rst), 0);
      model_reset();
      m_act = 1'b1;
      stop_chk = 1'b1;
      lr_periods(512, 2);
      chk("R10 no early lock", int'(ratio_locked), 0);
      lr_periods(512, 1);
      chk("R10 relock", int'(ratio_code), 4);
      chk("R10 relock flag", int'(ratio_locked), 1);

      m_act = 1'b0;
      stop_chk = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge osc_clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule